// File: doc/BRIEF.md
# Dual-Domain Timer Clock Prescaler

This block divides a clock down for an 8-bit timer and emits a one-cycle tick enable at the chosen ratio. A source-select input decides whether division happens on the system I/O clock or on a separate slow oscillator clock, for example from a 32.768 kHz watch crystal. There is one counter in each domain. Only the counter for the selected domain runs, and the other is held at zero. The I/O-domain counter drives `tick_io`, and the oscillator-domain counter drives `tick_osc`.

A small control register lives on the I/O clock, which is also the bus clock. It has three bits:
- bit 7 is a hold flag.
- bit 1 is a reset request for the timer prescaler.
- bit 0 is a reset request for the I/O-domain counter.

When the oscillator is selected, the bit-1 request crosses into the oscillator domain through a synchronizer, and an acknowledge returns through a second one. The bit reads one until that acknowledge has arrived, so software can poll it to learn when the reset has really happened. While the hold flag is set, hardware leaves both request bits standing, which keeps the prescaler in reset until software clears the flag.

Top module: `dual_dom_prescaler`

## Requirements
- R1: After reset `rd_data` reads 0x00. Bits 6 to 2 of `rd_data` always read zero, so writing 0xFF with the I/O source selected reads back 0x83.
- R2: A write with `wr_data[0]` or `wr_data[1]` set makes that bit read one. Writing zero to either bit leaves it unchanged. Bit 7 stores whatever is written to it.
- R3: `clk_sel` selects the divisor: 000 gives no ticks, 001 gives /1, 010 gives /8, 011 gives /32, 100 gives /64, 101 gives /128, 110 gives /256 and 111 gives /1024. The tick is high for one cycle of the selected clock, once every divisor cycles.
- R4: With `src_sel`=0 only `tick_io` pulses and `tick_osc` stays low. With `src_sel`=1 only `tick_osc` pulses and `tick_io` stays low.
- R5: Writing 1 to bit 0 while bit 7 is 0 sets the bit for exactly one I/O cycle. The counter restarts from zero, so with /8 the first tick follows the eighth I/O edge after the edge that takes the write.
- R6: With `src_sel`=0, bit 1 behaves exactly as bit 0 does in R5.
- R7: With `src_sel`=1, bit 1 stays one until the request has crossed into the oscillator domain and its acknowledge has come back through a two-flop synchronizer. It reads one for at least three I/O cycles after the write edge and then clears.
- R8: While bit 7 is one, set reset bits stay one and the affected counter emits no ticks.
- R9: Clearing bit 7 lets a set reset bit clear, after the handshake when the oscillator is selected. The counter then restarts from zero, so with /8 and the I/O source the first tick follows the eighth I/O edge after the write edge.
- R10: If a write sets a reset bit in the same cycle that hardware would clear it, the set wins and the bit stays one for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | System I/O clock, also the register bus clock |
| io_rst_n | input | 1 | Active-low asynchronous reset, I/O domain |
| osc_clk | input | 1 | Asynchronous oscillator clock |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| src_sel | input | 1 | 0 = divide the I/O clock, 1 = divide the oscillator clock |
| clk_sel | input | 3 | Divisor select code, held static while running |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit 7 hold, bit 1 prescaler reset, bit 0 I/O counter reset |
| rd_data | output | 8 | Register contents |
| tick_io | output | 1 | One-cycle tick enable in the I/O domain |
| tick_osc | output | 1 | One-cycle tick enable in the oscillator domain |

## Verification
A software write that sets a reset bit can coincide with the cycle in which hardware clears that same bit. The bench provokes this by holding the write strobe high for two consecutive I/O edges with bit 0 set. It then judges the result by the bit still reading one after the second edge and reading zero one edge later. The second pair of functions that can coincide is the hold flag being cleared while the oscillator-domain handshake is mid-flight. The bench checks this case by requiring the bit to clear within a bounded number of cycles and the tick period to come back exact.

// File: rtl/tps_pkg.sv
package tps_pkg;

   typedef enum logic [2:0] {
      TAP_STOP  = 3'd0,
      TAP_D1    = 3'd1,
      TAP_D8    = 3'd2,
      TAP_D32   = 3'd3,
      TAP_D64   = 3'd4,
      TAP_D128  = 3'd5,
      TAP_D256  = 3'd6,
      TAP_D1024 = 3'd7
   } tap_e;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_REQ  = 2'd1,
      HS_DROP = 2'd2
   } hs_e;

   // control register bit positions
   localparam int BIT_HOLD = 7;
   localparam int BIT_ARST = 1;
   localparam int BIT_SRST = 0;

   // widest tap needs this many counter bits
   localparam int MIN_CNT_W = 10;

   function automatic int tap_log2(tap_e s);
      case (s)
         TAP_D1:    return 0;
         TAP_D8:    return 3;
         TAP_D32:   return 5;
         TAP_D64:   return 6;
         TAP_D128:  return 7;
         TAP_D256:  return 8;
         TAP_D1024: return 10;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tps_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tps_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/tps_counter.sv
module tps_counter
   import tps_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  tap_e sel,
   output logic tick
);

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("tps_counter: CNT_W too small for the widest tap");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   always_comb mask = CNT_W'((32'd1 << tap_log2(sel)) - 32'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (hold) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assign tick = !hold && (sel != TAP_STOP) && ((cnt & mask) == mask);

   // R5
   hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tps_ctrl.sv
module tps_ctrl
   import tps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_hold,
   input  logic wr_arst,
   input  logic wr_srst,
   input  logic src_sel,
   input  logic ack_i,
   output logic sync_mode,
   output logic arst_q,
   output logic srst_q,
   output logic req_a
);

   hs_e  hs_q, hs_d;
   logic set_a, set_s, clr_a, clr_s;

   assign set_s = wr_en && wr_srst;
   assign set_a = wr_en && wr_arst;
   assign clr_s = !sync_mode;
   assign clr_a = !sync_mode && (src_sel ? (hs_q == HS_REQ && ack_i) : 1'b1);

   always_comb begin
      hs_d = hs_q;
      case (hs_q)
         HS_IDLE: if (arst_q && src_sel)    hs_d = HS_REQ;
         HS_REQ:  if (ack_i && !sync_mode)  hs_d = HS_DROP;
         HS_DROP: if (!ack_i)               hs_d = HS_IDLE;
         default:                           hs_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_mode <= 1'b0;
         arst_q    <= 1'b0;
         srst_q    <= 1'b0;
         hs_q      <= HS_IDLE;
      end else begin
         hs_q <= hs_d;
         if (wr_en)      sync_mode <= wr_hold;
         if (set_s)      srst_q <= 1'b1;
         else if (clr_s) srst_q <= 1'b0;
         if (set_a)      arst_q <= 1'b1;
         else if (clr_a) arst_q <= 1'b0;
      end
   end

   assign req_a = (hs_q == HS_REQ);

   // R8
   hold_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && srst_q) |=> srst_q);

   // R7
   async_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel && $fell(arst_q)) |-> $past(ack_i));

   // R2
   set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst_q) |-> $past(wr_en && wr_srst));

endmodule

// File: rtl/dual_dom_prescaler.sv
module dual_dom_prescaler
   import tps_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       io_clk,
   input  logic       io_rst_n,
   input  logic       osc_clk,
   input  logic       osc_rst_n,
   input  logic       src_sel,
   input  logic [2:0] clk_sel,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       tick_io,
   output logic       tick_osc
);

   localparam int XW = 2;

   logic sync_mode, arst_q, srst_q, req_a, ack_i;
   logic io_hold, osc_hold;
   logic [XW-1:0] osc_in, osc_out;
   logic wr_unused;
   tap_e sel;

   assign sel       = tap_e'(clk_sel);
   assign wr_unused = ^wr_data[6:2];

   tps_ctrl u_ctrl (
      .clk       (io_clk),
      .rst_n     (io_rst_n),
      .wr_en     (wr_en),
      .wr_hold   (wr_data[BIT_HOLD]),
      .wr_arst   (wr_data[BIT_ARST]),
      .wr_srst   (wr_data[BIT_SRST]),
      .src_sel   (src_sel),
      .ack_i     (ack_i),
      .sync_mode (sync_mode),
      .arst_q    (arst_q),
      .srst_q    (srst_q),
      .req_a     (req_a)
   );

   // request and source select into the oscillator domain
   assign osc_in = {src_sel, req_a};

   tps_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_to_osc (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .d     (osc_in),
      .q     (osc_out)
   );

   // acknowledge back into the I/O domain
   tps_sync #(.W(1), .STAGES(SYNC_STAGES)) u_to_io (
      .clk   (io_clk),
      .rst_n (io_rst_n),
      .d     (osc_out[0]),
      .q     (ack_i)
   );

   assign io_hold  = srst_q || (arst_q && !src_sel) || src_sel;
   assign osc_hold = osc_out[0] || !osc_out[1];

   tps_counter #(.CNT_W(CNT_W)) u_cnt_io (
      .clk   (io_clk),
      .rst_n (io_rst_n),
      .hold  (io_hold),
      .sel   (sel),
      .tick  (tick_io)
   );

   tps_counter #(.CNT_W(CNT_W)) u_cnt_osc (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .hold  (osc_hold),
      .sel   (sel),
      .tick  (tick_osc)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_HOLD] = sync_mode;
      rd_data[BIT_ARST] = arst_q;
      rd_data[BIT_SRST] = srst_q;
   end

   // R4
   src_excl_chk: assert property (@(posedge io_clk) disable iff (!io_rst_n)
      tick_io |-> !src_sel);

endmodule

// File: tb/dual_dom_prescaler_bench.sv
`timescale 1ns/1ps
module dual_dom_prescaler_bench;

   logic       io_clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       io_rst_n, osc_rst_n;
   logic       src_sel;
   logic [2:0] clk_sel;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       tick_io, tick_osc;

   int total = 0;
   int bad   = 0;

   always #4  io_clk  = ~io_clk;
   always #15 osc_clk = ~osc_clk;

   dual_dom_prescaler u_dual_dom_prescaler (
      .io_clk    (io_clk),
      .io_rst_n  (io_rst_n),
      .osc_clk   (osc_clk),
      .osc_rst_n (osc_rst_n),
      .src_sel   (src_sel),
      .clk_sel   (clk_sel),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .tick_io   (tick_io),
      .tick_osc  (tick_osc)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input int s);
      case (s)
         1: return 1;
         2: return 8;
         3: return 32;
         4: return 64;
         5: return 128;
         6: return 256;
         7: return 1024;
         default: return 0;
      endcase
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge io_clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge io_clk);
      @(negedge io_clk);
      wr_en = 1'b0;
   endtask

   // interval between two io ticks; also watches tick_osc stays low
   task automatic measure_io(input int exp, input string req);
      int n = 0;
      int osc_seen = 0;
      int guard = 0;
      do begin
         @(negedge io_clk);
         guard++;
      end while (!tick_io && guard < 3000);
      do begin
         @(negedge io_clk);
         n++;
         if (tick_osc) osc_seen++;
      end while (!tick_io && n < 3000);
      check(n == exp, req, n, exp);
      check(osc_seen == 0, "R4 tick_osc idle", osc_seen, 0);
   endtask

   task automatic measure_osc(input int exp, input string req);
      int n = 0;
      int guard = 0;
      do begin
         @(negedge osc_clk);
         guard++;
      end while (!tick_osc && guard < 3000);
      do begin
         @(negedge osc_clk);
         n++;
      end while (!tick_osc && n < 3000);
      check(n == exp, req, n, exp);
   endtask

   // after a write edge k: bit clears at k+1, first /8 tick after k+8
   task automatic restart_io(input int bitidx, input string req);
      int first = 0;
      wr(8'h01 << bitidx);
      check(rd_data[bitidx] == 1'b1, req, rd_data[bitidx], 1);
      for (int i = 1; i <= 8; i++) begin
         @(negedge io_clk);
         if (i == 1) check(rd_data[bitidx] == 1'b0, req, rd_data[bitidx], 0);
         if (tick_io && first == 0) first = i;
      end
      check(first == 8, req, first, 8);
   endtask

   task automatic do_reset();
      io_rst_n = 1'b0;
      osc_rst_n = 1'b0;
      src_sel = 1'b0;
      clk_sel = 3'd2;
      wr_en = 1'b0;
      wr_data = '0;
      repeat (5) @(negedge osc_clk);
      @(negedge io_clk);
      io_rst_n = 1'b1;
      osc_rst_n = 1'b1;
   endtask

   task automatic t_reset();
      @(negedge io_clk);
      check(rd_data == 8'h00, "R1 reset value", rd_data, 0);
   endtask

   task automatic t_taps();
      int cnt = 0;
      src_sel = 1'b0;
      for (int s = 1; s <= 7; s++) begin
         clk_sel = 3'(s);
         measure_io(div_of(s), "R3 io tap period");
      end
      clk_sel = 3'd0;
      for (int i = 0; i < 1100; i++) begin
         @(negedge io_clk);
         if (tick_io) cnt++;
      end
      check(cnt == 0, "R3 stop code", cnt, 0);
   endtask

   task automatic t_sync_reset();
      src_sel = 1'b0;
      clk_sel = 3'd2;
      restart_io(0, "R5 sync reset restart");
      restart_io(1, "R6 async bit with io source");
   endtask

   task automatic t_collision();
      @(negedge io_clk);
      wr_en = 1'b1;
      wr_data = 8'h01;
      @(posedge io_clk);
      @(negedge io_clk);
      check(rd_data[0] == 1'b1, "R10 set first", rd_data[0], 1);
      @(posedge io_clk);
      @(negedge io_clk);
      wr_en = 1'b0;
      check(rd_data[0] == 1'b1, "R10 set beats clear", rd_data[0], 1);
      @(posedge io_clk);
      @(negedge io_clk);
      check(rd_data[0] == 1'b0, "R10 clears after", rd_data[0], 0);
   endtask

   task automatic t_hold_io();
      int ticks = 0;
      int low = 0;
      int first = 0;
      src_sel = 1'b0;
      clk_sel = 3'd2;
      wr(8'hFF);
      check(rd_data == 8'h83, "R1 unused bits zero", rd_data, 8'h83);
      wr(8'h80);
      check(rd_data == 8'h83, "R2 zero write ignored", rd_data, 8'h83);
      for (int i = 0; i < 60; i++) begin
         @(negedge io_clk);
         if (tick_io) ticks++;
         if (rd_data[1:0] != 2'b11) low++;
      end
      check(ticks == 0, "R8 no io ticks in hold", ticks, 0);
      check(low == 0, "R8 bits stay set", low, 0);
      wr(8'h00);
      check(rd_data[7] == 1'b0, "R2 hold bit written", rd_data[7], 0);
      for (int i = 1; i <= 8; i++) begin
         @(negedge io_clk);
         if (i == 1) check(rd_data == 8'h00, "R9 bits clear on release", rd_data, 0);
         if (tick_io && first == 0) first = i;
      end
      check(first == 8, "R9 restart from zero", first, 8);
   endtask

   task automatic t_async_osc();
      int n = 0;
      int ticks = 0;
      int low = 0;
      int early = 0;
      src_sel = 1'b1;
      clk_sel = 3'd2;
      repeat (20) @(negedge io_clk);
      wr(8'h02);
      for (int i = 0; i < 3; i++) begin
         if (rd_data[1] != 1'b1) early++;
         @(negedge io_clk);
      end
      check(early == 0, "R7 bit held during handshake", early, 0);
      while (rd_data[1] && n < 60) begin
         @(negedge io_clk);
         n++;
      end
      check(rd_data[1] == 1'b0, "R7 bit clears after ack", rd_data[1], 0);
      measure_osc(8, "R3 osc tap period");
      for (int i = 0; i < 100; i++) begin
         @(negedge io_clk);
         if (tick_io) ticks++;
      end
      check(ticks == 0, "R4 tick_io idle", ticks, 0);
      wr(8'h82);
      ticks = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge io_clk);
         if (!rd_data[1]) low++;
         if (i >= 25 && tick_osc) ticks++;
      end
      check(low == 0, "R8 async bit held", low, 0);
      check(ticks == 0, "R8 no osc ticks in hold", ticks, 0);
      wr(8'h00);
      n = 0;
      while (rd_data[1] && n < 60) begin
         @(negedge io_clk);
         n++;
      end
      check(rd_data[1] == 1'b0, "R9 async bit clears on release", rd_data[1], 0);
      measure_osc(8, "R9 osc ticks resume");
   endtask

   initial begin
      do_reset();
      t_reset();
      t_taps();
      t_sync_reset();
      t_collision();
      t_hold_io();
      t_async_osc();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge io_clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule